// File: doc/BRIEF.md
# Byte-Lane Data Bus Inversion Codec

This block sits in the data path of a DDR4 memory controller and applies data bus inversion to each byte lane, in both directions. On the write side, every outgoing byte is examined: if it carries more than four zero bits it is sent complemented and the lane's active-low inversion flag is driven low. Otherwise the byte goes out as is and the flag stays high. As a result, no more than four of the nine lines of a lane (eight data lines plus the flag) are ever low after encoding. This cuts simultaneous switching noise and termination power on a pseudo-open-drain bus.

On the read side, the received byte is complemented back whenever its flag arrives low. A shared enable turns the feature off. With the enable low, write flags stay high and data passes through untouched in both directions. This is the setting for x4 devices, or for lanes whose flag pin is serving as a data mask.

Beats are processed independently. Each direction has its own valid qualifier and a single register stage. The lane count is a parameter: one lane models a x8 device, two lanes a x16 device, and each lane keeps its own flag.

Top module: `dbi_codec`

## Requirements
- R1: After reset both valid outputs are 0, every write flag bit is 1, and the write and read data outputs are all zero.
- R2: With the enable high, a write byte whose count of 0 bits is 5 or more is output as its bitwise complement, and that lane's flag is 0.
- R3: With the enable high, a write byte with at most 4 zero bits (exactly 4 included) is output unchanged, and that lane's flag is 1.
- R4: With the enable high, each encoded lane shows at most 4 low lines among its 8 data bits and its flag.
- R5: With the enable high, a read byte whose flag is 0 is output complemented; a read byte whose flag is 1 is output unchanged.
- R6: With the enable low, the write flag is 1 and the write data passes unchanged, and read data passes unchanged whatever the read flag says.
- R7: Each output valid equals its input valid one clock earlier. The data and flag carried with that valid belong to that same beat.
- R8: Lanes are independent. Lane k uses data bits [8k+7:8k] and flag bit k, and the decision for one lane never depends on another lane.
- R9: In a cycle that follows a cycle with no input valid, that direction's data and flag outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_en | input | 1 | Inversion enable, sampled with each beat |
| wr_valid_i | input | 1 | Write beat present |
| wr_data_i | input | LANES*8 | Write data before encoding |
| wr_valid_o | output | 1 | Encoded write beat present |
| wr_data_o | output | LANES*8 | Encoded write data |
| wr_dbi_n_o | output | LANES | Active-low inversion flag, one per lane |
| rd_valid_i | input | 1 | Read beat present |
| rd_data_i | input | LANES*8 | Received read data |
| rd_dbi_n_i | input | LANES | Received active-low inversion flag, one per lane |
| rd_valid_o | output | 1 | Decoded read beat present |
| rd_data_o | output | LANES*8 | Restored read data |

## Verification
The bench goes after the threshold edge, where a byte holds exactly four zeros versus five. A design that compares with "at least four" would invert a 0x0F byte, and one that counts ones instead of zeros would flip the wrong half of the value range. A full sweep of all 256 byte values, with the second lane holding the complement, catches lanes that are swapped or share one decision. It also checks the nine-line low budget on every beat. With the enable low, the bench drives all-zero writes and read flags held low: a design that ignored the enable would raise the low count or corrupt read data. Idle cycles placed between beats expose an output register that reloads without a valid, and a comparison of every cycle's valid against the previous cycle's input shows any stage that is missing or doubled.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned ZCNT_W    = $clog2(LANE_W + 1);
  localparam int unsigned LOW_LIMIT = LANE_W / 2;
  localparam int unsigned LINE_HALF = (LANE_W + 1) / 2;

  typedef logic [LANE_W-1:0] lane_t;

  // number of zero bits in one lane byte
  function automatic logic [ZCNT_W-1:0] zero_count(input lane_t b);
    logic [ZCNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < LANE_W; i++) begin
      if (!b[i]) n = n + ZCNT_W'(1);
    end
    return n;
  endfunction

  // true when the byte would pull more than half the data lines low
  function automatic logic zero_heavy(input lane_t b);
    return zero_count(b) > ZCNT_W'(LOW_LIMIT);
  endfunction

  function automatic lane_t cond_flip(input lane_t b, input logic f);
    return f ? ~b : b;
  endfunction
endpackage

// File: rtl/dbi_wr_lane.sv
module dbi_wr_lane
  import dbi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  load,
  input  lane_t din,
  output lane_t dout,
  output logic  dbi_n
);
  logic flip;   // this beat will be complemented
  logic en_q;   // enable that applied to the held beat

  assign flip = en && zero_heavy(din);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= '0;
      dbi_n <= 1'b1;
      en_q  <= 1'b0;
    end else if (load) begin
      dout  <= cond_flip(din, flip);
      dbi_n <= ~flip;
      en_q  <= en;
    end
  end

  // R2: heavy byte is complemented with flag low
  a_r2_heavy_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    load && en && zero_heavy(din) |=> !dbi_n && (dout == ~$past(din)));

  // R3: light byte passes with flag high
  a_r3_light_passed: assert property (@(posedge clk) disable iff (!rst_n)
    load && en && !zero_heavy(din) |=> dbi_n && (dout == $past(din)));

  // R4: at most half of the nine lane lines low once encoded
  a_r4_low_budget: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> ($countones(~{dbi_n, dout}) <= LINE_HALF));

  // R6: disabled write keeps flag high and data untouched
  a_r6_wr_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    load && !en |=> dbi_n && (dout == $past(din)));
endmodule

// File: rtl/dbi_rd_lane.sv
module dbi_rd_lane
  import dbi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  load,
  input  lane_t din,
  input  logic  dbi_n_in,
  output lane_t dout
);
  logic unflip;  // received beat must be complemented back

  assign unflip = en && !dbi_n_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (load) begin
      dout <= cond_flip(din, unflip);
    end
  end

  // R5: low flag restores complemented byte
  a_r5_restore: assert property (@(posedge clk) disable iff (!rst_n)
    load && en && !dbi_n_in |=> dout == ~$past(din));

  // R5: high flag leaves byte as received
  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    load && en && dbi_n_in |=> dout == $past(din));

  // R6: disabled read ignores the flag
  a_r6_rd_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    load && !en |=> dout == $past(din));
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
  import dbi_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inv_en,
  input  logic                     wr_valid_i,
  input  logic [LANES*LANE_W-1:0]  wr_data_i,
  output logic                     wr_valid_o,
  output logic [LANES*LANE_W-1:0]  wr_data_o,
  output logic [LANES-1:0]         wr_dbi_n_o,
  input  logic                     rd_valid_i,
  input  logic [LANES*LANE_W-1:0]  rd_data_i,
  input  logic [LANES-1:0]         rd_dbi_n_i,
  output logic                     rd_valid_o,
  output logic [LANES*LANE_W-1:0]  rd_data_o
);
  localparam int unsigned DW = LANES * LANE_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid_o <= 1'b0;
      rd_valid_o <= 1'b0;
    end else begin
      wr_valid_o <= wr_valid_i;
      rd_valid_o <= rd_valid_i;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    dbi_wr_lane u_wr (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (inv_en),
      .load  (wr_valid_i),
      .din   (wr_data_i[k*LANE_W +: LANE_W]),
      .dout  (wr_data_o[k*LANE_W +: LANE_W]),
      .dbi_n (wr_dbi_n_o[k])
    );
    dbi_rd_lane u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (inv_en),
      .load     (rd_valid_i),
      .din      (rd_data_i[k*LANE_W +: LANE_W]),
      .dbi_n_in (rd_dbi_n_i[k]),
      .dout     (rd_data_o[k*LANE_W +: LANE_W])
    );
  end

  // R7: one register stage on each valid
  a_r7_wr_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o == $past(wr_valid_i));
  a_r7_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o == $past(rd_valid_i));

  // R9: outputs hold over idle cycles
  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid_i |=> $stable(wr_data_o) && $stable(wr_dbi_n_o));
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> $stable(rd_data_o));

  initial begin
    a_r8_lane_count: assert (DW == LANES * LANE_W && LANES >= 1);
  end
endmodule

// File: tb/tb_dbi_codec.sv
module tb_dbi_codec;
  localparam int LANES = 2;
  localparam int DW    = LANES * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inv_en = 1'b1;
  logic wr_valid_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic wr_valid_o;
  logic [DW-1:0] wr_data_o;
  logic [LANES-1:0] wr_dbi_n_o;
  logic rd_valid_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic [LANES-1:0] rd_dbi_n_i = '1;
  logic rd_valid_o;
  logic [DW-1:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbi_codec #(.LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .inv_en(inv_en),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .wr_dbi_n_o(wr_dbi_n_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .rd_dbi_n_i(rd_dbi_n_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write model: flag bits above data bits
  function automatic logic [DW+LANES-1:0] model_wr(input logic [DW-1:0] d, input logic en);
    logic [DW-1:0] o;
    logic [LANES-1:0] f;
    for (int l = 0; l < LANES; l++) begin
      logic [7:0] b;
      b = d[l*8 +: 8];
      if (en && $countones(~b) >= 5) begin
        o[l*8 +: 8] = ~b;
        f[l] = 1'b0;
      end else begin
        o[l*8 +: 8] = b;
        f[l] = 1'b1;
      end
    end
    return {f, o};
  endfunction

  function automatic logic [DW-1:0] model_rd(input logic [DW-1:0] d,
                                              input logic [LANES-1:0] f, input logic en);
    logic [DW-1:0] o;
    for (int l = 0; l < LANES; l++)
      o[l*8 +: 8] = (en && !f[l]) ? ~d[l*8 +: 8] : d[l*8 +: 8];
    return o;
  endfunction

  // scoreboard queues
  logic [DW+LANES-1:0] wq[$];
  logic                weq[$];
  string               wtag[$];
  logic [DW-1:0]       rq[$];
  string               rtag[$];

  task automatic drive_wr(input logic [DW-1:0] d, input logic en, input string tag);
    @(posedge clk); #1;
    wr_valid_i = 1'b1; wr_data_i = d; inv_en = en;
    wq.push_back(model_wr(d, en)); weq.push_back(en); wtag.push_back(tag);
  endtask

  task automatic drive_rd(input logic [DW-1:0] d, input logic [LANES-1:0] f,
                          input logic en, input string tag);
    @(posedge clk); #1;
    rd_valid_i = 1'b1; rd_data_i = d; rd_dbi_n_i = f; inv_en = en;
    rq.push_back(model_rd(d, f, en)); rtag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      wr_valid_i = 1'b0; rd_valid_i = 1'b0;
      wr_data_i = 16'hA5C3; rd_data_i = 16'h3C5A; rd_dbi_n_i = 2'b00;
    end
  endtask

  // monitor
  logic prev_wr = 1'b0, prev_rd = 1'b0;
  logic [DW-1:0] last_wd = '0, last_rd = '0;
  logic [LANES-1:0] last_wf = '1;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(wr_valid_o == prev_wr, "R7 write valid latency", 32'(wr_valid_o), 32'(prev_wr));
      check(rd_valid_o == prev_rd, "R7 read valid latency", 32'(rd_valid_o), 32'(prev_rd));
      if (wr_valid_o) begin
        if (wq.size() == 0) check(1'b0, "R7 write beat with empty queue", 32'(wr_data_o), 0);
        else begin
          logic [DW+LANES-1:0] e;
          logic en;
          string t;
          e = wq.pop_front(); en = weq.pop_front(); t = wtag.pop_front();
          check({wr_dbi_n_o, wr_data_o} == e, t, 32'({wr_dbi_n_o, wr_data_o}), 32'(e));
          if (en) begin
            for (int l = 0; l < LANES; l++)
              check($countones(~{wr_dbi_n_o[l], wr_data_o[l*8 +: 8]}) <= 4,
                    "R4 low line budget",
                    32'($countones(~{wr_dbi_n_o[l], wr_data_o[l*8 +: 8]})), 4);
          end
        end
      end else begin
        check({wr_dbi_n_o, wr_data_o} == {last_wf, last_wd}, "R9 write hold",
              32'({wr_dbi_n_o, wr_data_o}), 32'({last_wf, last_wd}));
      end
      if (rd_valid_o) begin
        if (rq.size() == 0) check(1'b0, "R7 read beat with empty queue", 32'(rd_data_o), 0);
        else begin
          logic [DW-1:0] e;
          string t;
          e = rq.pop_front(); t = rtag.pop_front();
          check(rd_data_o == e, t, 32'(rd_data_o), 32'(e));
        end
      end else begin
        check(rd_data_o == last_rd, "R9 read hold", 32'(rd_data_o), 32'(last_rd));
      end
      last_wd = wr_data_o; last_wf = wr_dbi_n_o; last_rd = rd_data_o;
      prev_wr = wr_valid_i; prev_rd = rd_valid_i;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(wr_valid_o == 1'b0, "R1 write valid after reset", 32'(wr_valid_o), 0);
    check(rd_valid_o == 1'b0, "R1 read valid after reset", 32'(rd_valid_o), 0);
    check(wr_dbi_n_o == '1, "R1 flags after reset", 32'(wr_dbi_n_o), 3);
    check(wr_data_o == '0 && rd_data_o == '0, "R1 data after reset",
          32'({wr_data_o, rd_data_o}), 0);

    drive_wr(16'h0000, 1'b1, "R2 all zero inverted");
    drive_wr(16'h0701, 1'b1, "R2 five and seven zeros");
    drive_wr(16'h0F0F, 1'b1, "R3 exactly four zeros");
    drive_wr(16'hFFFF, 1'b1, "R3 all ones");
    drive_wr(16'hE11E, 1'b1, "R3 four zeros mixed");
    drive_wr(16'h00FF, 1'b1, "R8 only upper lane inverted");
    drive_wr(16'hFF00, 1'b1, "R8 only lower lane inverted");
    idle(2);
    drive_wr(16'h0000, 1'b0, "R6 disabled write zero");
    drive_wr(16'h1248, 1'b0, "R6 disabled write pattern");
    idle(1);
    for (int v = 0; v < 256; v++) begin
      drive_wr({~8'(v), 8'(v)}, 1'b1, "R2 R3 R8 sweep");
      if (v % 37 == 0) idle(1);
    end
    idle(2);

    drive_rd(16'hF0F0, 2'b00, 1'b1, "R5 both flags low");
    drive_rd(16'hF0F0, 2'b11, 1'b1, "R5 both flags high");
    drive_rd(16'h1234, 2'b01, 1'b1, "R5 R8 upper flag low");
    drive_rd(16'h1234, 2'b10, 1'b1, "R5 R8 lower flag low");
    idle(1);
    drive_rd(16'h5A5A, 2'b00, 1'b0, "R6 disabled read ignores flags");
    drive_rd(16'h0000, 2'b00, 1'b0, "R6 disabled read zero");
    idle(1);
    for (int v = 0; v < 256; v += 3) begin
      logic [DW+LANES-1:0] enc;
      enc = model_wr({8'(v), ~8'(v)}, 1'b1);
      drive_rd(enc[DW-1:0], enc[DW +: LANES], 1'b1, "R5 round trip");
    end
    idle(4);

    check(wq.size() == 0 && rq.size() == 0, "R7 all beats delivered",
          32'(wq.size() + rq.size()), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule